// File: doc/BRIEF.md
# Compare-Match Watchdog Interval Timer

This block is a small supervisory timer that advances once for every overflow pulse coming from an upstream interval timer. It holds a 7-bit count and compares it with a software-programmed 7-bit limit. When the count reaches the limit on a tick, the block produces a match event and the counter starts over from zero. A programmed limit of N therefore yields one event every N+1 ticks.

A routing bit decides what a match does. In reset routing the match becomes a single-cycle request to reset the processor, which suits malfunction detection: software must keep restarting the counter before the limit is reached. In interrupt routing the match sets a sticky interrupt flag that software acknowledges, so the block serves as a periodic interrupt source.

The limit and a restart command share one 8-bit register. Writing bit 7 as 1 restarts the counter. That bit reads back as 1 for one cycle and then falls to 0 by itself. The oscillator and the prescaler that feed the tick input are outside this block.

Top module: `wdog_cmp_timer`

## Requirements
- R1: After synchronous reset the register reads 0x7F (restart bit 0, limit 127), the interrupt flag is 0, the reset request is 0, routing is interrupt (routing bit 0) and the count is 0.
- R2: A register write stores wr_data_i[6:0] as the limit. In the cycle after the write, rd_data_o reads {wr_data_i[7], limit}. In the cycle after that, bit 7 reads 0 unless it was written as 1 again.
- R3: The count rises by exactly one on each cycle with tick_i high. On a cycle without a tick it is unchanged, so idle cycles between ticks do not shift the match.
- R4: After the count returns to 0, the match occurs on the (limit+1)-th tick, and the count is 0 again after the match.
- R5: While the restart bit reads 1, the next clock edge sets the count to 0, and a tick in that cycle is not counted. A restart in the middle of a period starts a full new period.
- R6: With routing bit 1, a match drives rst_req_o high for exactly the one cycle after the matching edge and leaves the interrupt flag unchanged.
- R7: With routing bit 0, a match sets irq_flag_o from the next cycle on. The flag then stays set until it is acknowledged, and rst_req_o stays 0.
- R8: A cycle with irq_ack_i high clears the flag. If a match in interrupt routing falls in the same cycle as the acknowledge, the flag stays set.
- R9: A limit of 0 gives a match on every tick.
- R10: The count wraps from 127 to 0 without a match when the limit is not 127. A limit lowered below the present count is therefore reached only after the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle overflow pulse from the interval timer |
| wr_en_i | input | 1 | Write strobe for the limit/restart register |
| wr_data_i | input | CNT_W+1 (8) | Write data: bit 7 restart, bits 6:0 limit |
| mode_we_i | input | 1 | Write strobe for the routing bit |
| mode_d_i | input | 1 | Routing bit value: 1 reset request, 0 interrupt |
| irq_ack_i | input | 1 | Acknowledge strobe that clears the interrupt flag |
| rd_data_o | output | CNT_W+1 (8) | Register read: restart bit and limit |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| rst_req_o | output | 1 | One-cycle processor reset request |

## Verification
The bound checker watches, on every cycle, how a match becomes a reset pulse or a flag, that the flag holds until it is acknowledged, that the restart bit falls by itself, that a restart forces the count to zero and that the count moves by one only on ticks. The exact length of a period cannot be checked cycle by cycle. Only the bench scenarios show it: limits of 127, 5, 3 and 0, wrap-around after a lowered limit, a restart in the middle of a period, and an acknowledge that meets a match in the same cycle. The bench sees these only at the ports, through the timing of the flag and the reset request.

// File: rtl/wdt_cmp_pkg.sv
package wdt_cmp_pkg;
  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_RST = 1'b1
  } route_e;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_cmp_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW:0]   wr_data,
  input  logic          mode_we,
  input  logic          mode_d,
  output logic [CW-1:0] cmp_val,
  output logic          clr_bit,
  output route_e        route,
  output logic [CW:0]   rd_data
);
  localparam logic [CW-1:0] CMP_RST = {CW{1'b1}};

  // limit register and self-clearing restart bit
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= CMP_RST;
      clr_bit <= 1'b0;
    end else begin
      if (wr_en) cmp_val <= wr_data[CW-1:0];
      clr_bit <= wr_en ? wr_data[CW] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          route <= ROUTE_IRQ;
    else if (mode_we) route <= route_e'(mode_d);
  end

  assign rd_data = {clr_bit, cmp_val};
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] cmp_val,
  output logic [CW-1:0] count,
  output logic          hit
);
  function automatic logic is_match(input logic [CW-1:0] c, input logic [CW-1:0] lim);
    return c == lim;
  endfunction

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic m);
    return m ? '0 : c + 1'b1;
  endfunction

  assign hit = tick && !clr && is_match(count, cmp_val);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= step(count, hit);
  end
endmodule

// File: rtl/wdt_route.sv
module wdt_route
  import wdt_cmp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hit,
  input  route_e route,
  input  logic   ack,
  output logic   irq_flag,
  output logic   rst_req
);
  logic irq_set;
  logic rst_set;

  assign irq_set = hit && (route == ROUTE_IRQ);
  assign rst_set = hit && (route == ROUTE_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      rst_req <= rst_set;
      if (irq_set)  irq_flag <= 1'b1;
      else if (ack) irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_cmp_timer.sv
module wdog_cmp_timer
  import wdt_cmp_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W:0]   wr_data_i,
  input  logic             mode_we_i,
  input  logic             mode_d_i,
  input  logic             irq_ack_i,
  output logic [CNT_W:0]   rd_data_o,
  output logic             irq_flag_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] count_w;
  logic             clr_w;
  logic             hit_w;
  route_e           route_w;
  logic             mode_w;

  assign mode_w = (route_w == ROUTE_RST);

  wdt_regif #(.CW(CNT_W)) u_regif (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .mode_we (mode_we_i),
    .mode_d  (mode_d_i),
    .cmp_val (cmp_w),
    .clr_bit (clr_w),
    .route   (route_w),
    .rd_data (rd_data_o)
  );

  wdt_counter #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .clr     (clr_w),
    .cmp_val (cmp_w),
    .count   (count_w),
    .hit     (hit_w)
  );

  wdt_route u_route (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit_w),
    .route    (route_w),
    .ack      (irq_ack_i),
    .irq_flag (irq_flag_o),
    .rst_req  (rst_req_o)
  );
endmodule

// File: rtl/wdog_cmp_timer_chk.sv
module wdog_cmp_timer_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic          irq_ack_i,
  input logic          hit_w,
  input logic          mode_w,
  input logic          clr_w,
  input logic [CW-1:0] count_w,
  input logic          irq_flag_o,
  input logic          rst_req_o
);
  AST_CLR_SELF_DROP: assert property (@(posedge clk) disable iff (rst)
    clr_w && !wr_en_i |=> !clr_w); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i && !clr_w |=> $stable(count_w)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_i && !clr_w && !hit_w |=> (count_w - $past(count_w)) == CW'(1)); // R3

  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> count_w == '0); // R4

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> count_w == '0); // R5

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    hit_w && mode_w |=> rst_req_o); // R6

  AST_RST_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    !(hit_w && mode_w) |=> !rst_req_o); // R6

  AST_RST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    hit_w && mode_w && !irq_ack_i |=> $stable(irq_flag_o)); // R6

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    hit_w && !mode_w |=> irq_flag_o); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_flag_o && !irq_ack_i |=> irq_flag_o); // R7

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
    irq_ack_i && !(hit_w && !mode_w) |=> !irq_flag_o); // R8
endmodule

bind wdog_cmp_timer wdog_cmp_timer_chk #(.CW(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .irq_ack_i  (irq_ack_i),
  .hit_w      (hit_w),
  .mode_w     (mode_w),
  .clr_w      (clr_w),
  .count_w    (count_w),
  .irq_flag_o (irq_flag_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/wdog_cmp_timer_tb_top.sv
module wdog_cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, we = 1'b0, mwe = 1'b0, md = 1'b0, ack = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       irq, rreq;

  always #2 clk = ~clk;  // 250 MHz

  wdog_cmp_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(we), .wr_data_i(wd),
    .mode_we_i(mwe), .mode_d_i(md), .irq_ack_i(ack),
    .rd_data_o(rd), .irq_flag_o(irq), .rst_req_o(rreq)
  );

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    logic       rr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // bench view of the requirements
  logic [6:0] b_lim   = 7'h7F;
  logic       b_clr   = 1'b0;
  logic       b_mode  = 1'b0;
  logic       b_flag  = 1'b0;
  int         b_ticks = 0;   // ticks counted since last restart

  task automatic drive(input logic t, input logic w, input logic [7:0] d,
                       input logic mw, input logic m, input logic a, input string tag);
    exp_t e;
    logic match;
    @(negedge clk);
    tick = t; we = w; wd = d; mwe = mw; md = m; ack = a;
    // R4: match on the (limit+1)-th tick; R5: tick ignored while restart bit is 1
    match = t && !b_clr && (b_ticks == int'(b_lim));
    if (b_clr || match) b_ticks = 0;
    else if (t)         b_ticks = (b_ticks + 1) % 128;  // R10 wrap
    if (match && !b_mode) b_flag = 1'b1;                // R7
    else if (a)           b_flag = 1'b0;                // R8
    e.rr = match && b_mode;                             // R6
    if (mw) b_mode = m;
    if (w)  b_lim = d[6:0];
    b_clr = w ? d[7] : 1'b0;                            // R2
    e.rd  = {b_clr, b_lim};
    e.irq = b_flag;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 0, 0, 0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1, 0, 8'h00, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    drive(0, 1, d, 0, 0, 0, tag);
  endtask

  task automatic setmode(input logic m, input string tag);
    drive(0, 0, 8'h00, 1, m, 0, tag);
  endtask

  task automatic acknowledge(input string tag);
    drive(0, 0, 8'h00, 0, 0, 1, tag);
  endtask

  // monitor: compare design outputs one time unit after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if (rd !== e.rd) begin
          n_bad++;
          $display("FAIL %s rd_data got %h exp %h", e.tag, rd, e.rd);
        end
        if (irq !== e.irq) begin
          n_bad++;
          $display("FAIL %s irq_flag got %b exp %b", e.tag, irq, e.irq);
        end
        if (rreq !== e.rr) begin
          n_bad++;
          $display("FAIL %s rst_req got %b exp %b", e.tag, rreq, e.rr);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog timeout, got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    idle(2, "R1");
    // R4 default limit 127: match on tick 128; R7 flag sticky
    ticks(127, "R4");
    ticks(1, "R4");
    idle(3, "R7");
    acknowledge("R8");
    // R2 write limit 5 with restart, read-back and self-clear; R5 tick ignored
    wr(8'h85, "R2");
    drive(1, 0, 8'h00, 0, 0, 0, "R5");
    idle(1, "R2");
    ticks(6, "R4");
    acknowledge("R8");
    // R3 ticks with gaps
    for (int i = 0; i < 14; i++) begin
      ticks(1, "R3");
      idle(i % 3, "R3");
    end
    acknowledge("R8");
    // R8 acknowledge meets a match: flag stays set
    wr(8'h85, "R8");
    idle(1, "R8");
    ticks(5, "R8");
    drive(1, 0, 8'h00, 0, 0, 1, "R8");
    idle(1, "R8");
    acknowledge("R8");
    // R6 reset routing, limit 3
    setmode(1, "R6");
    wr(8'h83, "R6");
    idle(1, "R6");
    ticks(9, "R6");
    // R9 limit 0 in both routings
    wr(8'h80, "R9");
    idle(1, "R9");
    ticks(4, "R9");
    setmode(0, "R9");
    wr(8'h80, "R9");
    idle(1, "R9");
    ticks(3, "R9");
    acknowledge("R8");
    // R10 limit lowered below count: reached after wrap
    wr(8'h9E, "R10");
    idle(1, "R10");
    ticks(20, "R10");
    wr(8'h0A, "R10");
    ticks(120, "R10");
    acknowledge("R8");
    // R5 restart in the middle of a period
    wr(8'h88, "R5");
    idle(1, "R5");
    ticks(5, "R5");
    wr(8'h88, "R5");
    idle(1, "R5");
    ticks(10, "R5");
    idle(3, "R5");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule